// File: doc/BRIEF.md
# Serial Control Port for a 16-bit Successive-Approximation Converter

This block is the digital side of a serial converter port. A host lowers chip select and toggles a serial clock. A logic one on the data input marks the start of a transaction. The seven bits after it form a control word. That word picks the output coding, whether the conversion is timed by the host's serial clock or by an on-chip timer, and the length of the acquisition window. The block then runs the conversion sequence and shifts the 16-bit result out MSB first on the data output. A strobe output marks the point where the data becomes valid.

All serial inputs are asynchronous to the system clock. Each one passes through a two-stage synchroniser and an edge detector. The analog front end is not part of the block. The raw conversion code arrives on a parallel port as offset binary, and a one-cycle pulse tells the analog side when a conversion starts. In internal-clock mode a counter of system-clock cycles plays the role of the conversion time. The result is then held until the host reads it, at whatever pace suits the host.

Top module: `sar_serial_port`

## Requirements
- R1: With chip select low and no transaction running, a 1 on `din` at a rising SCLK edge starts a transaction. The next seven rising edges capture the control bits in this order: coding (1 unipolar, 0 bipolar), clock source (1 internal, 0 external), M1, M0, P2, P1, P0. After the 8th falling edge `ctl_word` shows the first of these bits at bit 6 and the last at bit 0.
- R2: `conv_start` pulses high for exactly one system clock at the 8th falling SCLK edge of the transaction.
- R3: In external mode the strobe goes high after the falling edge numbered E and low again after falling edge E+1. Edges are counted from the start bit, with E = 15 when M1 = 1 and E = `SHORT_EDGE` (default 11) when M1 = 0. The strobe is low at every other falling edge from the 9th onwards.
- R4: In external mode the result MSB is on `dout` after falling edge E+1. Each of the next 15 falling edges presents the next lower bit.
- R5: `strobe_oe` is low whenever `cs_n` is high in external mode. It is high while `cs_n` is low, and it is always high in internal mode.
- R6: In external mode, SCLK edges while `cs_n` is high have no effect. Counting resumes when `cs_n` falls again, so a transfer may be split into 8-bit groups.
- R7: In internal mode the strobe is low for exactly `CONV_CYCLES` system clocks, counted from the `conv_start` cycle. It then goes high with the MSB on `dout`, and it stays high until the next conversion starts.
- R8: In internal mode the 15 falling edges after the strobe rises present the remaining bits. `cs_n` may be high during the conversion.
- R9: `res_data` is offset binary. Unipolar coding presents it unchanged. Bipolar coding inverts its MSB, which gives two's complement.
- R10: After the LSB, further falling SCLK edges present 0 on `dout`.
- R11: A 1 on `din` during a readout does not start a transaction. In internal mode, once `cs_n` has been high during the readout, a start bit begins a new transaction.
- R12: After reset `dout`, `strobe` and `ctl_word` are 0, the block is in external mode, and `strobe_oe` is 0 while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| din | input | 1 | Serial data in, asynchronous |
| res_data | input | W | Raw conversion code, offset binary |
| dout | output | 1 | Serial result, MSB first |
| strobe | output | 1 | Data-ready strobe level |
| strobe_oe | output | 1 | Strobe drive enable (low means high impedance) |
| conv_start | output | 1 | One-cycle conversion start pulse |
| ctl_word | output | 7 | Captured control bits |

## Verification
A wrong falling-edge count shows up as a strobe pulse one SCLK period early or late, and the MSB then lands on the wrong edge. A lost or extra shift shifts every following bit, so the error shows within one SCLK period of the fault. A bad timer value changes the strobe low time measured in system clocks. A wrong coding choice flips exactly the first bit read out. A state machine that goes back to idle too early or too late shows as a zero tail that is missing or starts late. A start bit that is wrongly accepted changes `ctl_word` or cuts off the readout.

// File: rtl/sarp_pkg.sv
package sarp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_EXTW,
      ST_CONV,
      ST_READ
   } sarp_state_e;

   typedef struct packed {
      logic       unip;
      logic       intclk;
      logic       m1;
      logic       m0;
      logic [2:0] pb;
   } sarp_ctl_t;
endpackage

// File: rtl/sarp_sync.sv
module sarp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sarp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/sarp_shift.sv
module sarp_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic         unip,
   input  logic [W-1:0] res,
   output logic         dout
);
   logic [W-1:0] sr;
   logic [W-1:0] coded;

   // bipolar: offset binary to two's complement by MSB inversion
   assign coded = unip ? res : {~res[W-1], res[W-2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (load)  sr <= coded;
      else if (shift) sr <= {sr[W-2:0], 1'b0};
   end

   assign dout = sr[W-1];
endmodule

// File: rtl/sarp_seq.sv
module sarp_seq
   import sarp_pkg::*;
#(
   parameter int W           = 16,
   parameter int CONV_CYCLES = 700,
   parameter int SHORT_EDGE  = 11
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_lo,
   input  logic        rise,
   input  logic        fall,
   input  logic        din_s,
   output sarp_state_e st,
   output sarp_ctl_t   ctl,
   output logic        conv_start,
   output logic        strobe,
   output logic        load,
   output logic        shift
);
   localparam int CW = $clog2(W + 3);
   localparam int TW = $clog2(CONV_CYCLES + 1);
   localparam int RW = $clog2(W + 1);
   localparam logic [CW-1:0] LONG_E  = CW'(W - 1);
   localparam logic [CW-1:0] SHORT_E = CW'(SHORT_EDGE);
   localparam logic [CW-1:0] CMD_END = CW'(7);
   localparam logic [TW-1:0] T_LAST  = TW'(CONV_CYCLES - 1);
   localparam logic [RW-1:0] R_LAST  = RW'(W - 1);

   generate
      if (SHORT_EDGE <= 8 || SHORT_EDGE > W - 1) begin : g_bad_edge
         $error("sarp_seq: SHORT_EDGE out of range");
      end
      if (CONV_CYCLES < 1) begin : g_bad_conv
         $error("sarp_seq: CONV_CYCLES must be positive");
      end
   endgenerate

   logic [CW-1:0] fcnt;
   logic [CW-1:0] fnext;
   logic [CW-1:0] strb_e;
   logic [TW-1:0] tmr;
   logic [RW-1:0] rcnt;
   logic [6:0]    ctl_sh;
   logic          armed;

   assign fnext  = fcnt + 1'b1;
   assign strb_e = ctl.m1 ? LONG_E : SHORT_E;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         ctl        <= '0;
         ctl_sh     <= '0;
         fcnt       <= '0;
         tmr        <= '0;
         rcnt       <= '0;
         armed      <= 1'b0;
         conv_start <= 1'b0;
         strobe     <= 1'b0;
         load       <= 1'b0;
         shift      <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         load       <= 1'b0;
         shift      <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (cs_lo && rise && din_s) begin
                  st   <= ST_CMD;
                  fcnt <= '0;
               end
            end
            ST_CMD: begin
               if (cs_lo && rise) ctl_sh <= {ctl_sh[5:0], din_s};
               if (cs_lo && fall) begin
                  fcnt <= fnext;
                  if (fcnt == CMD_END) begin
                     ctl        <= sarp_ctl_t'(ctl_sh);
                     conv_start <= 1'b1;
                     strobe     <= 1'b0;
                     if (ctl_sh[5]) begin
                        st  <= ST_CONV;
                        tmr <= '0;
                     end else begin
                        st  <= ST_EXTW;
                     end
                  end
               end
            end
            ST_EXTW: begin
               if (cs_lo && fall) begin
                  fcnt <= fnext;
                  if (fnext == strb_e) begin
                     strobe <= 1'b1;
                  end else if (fnext == strb_e + 1'b1) begin
                     strobe <= 1'b0;
                     load   <= 1'b1;
                     st     <= ST_READ;
                     rcnt   <= '0;
                     armed  <= 1'b0;
                  end
               end
            end
            ST_CONV: begin
               tmr <= tmr + 1'b1;
               if (tmr == T_LAST) begin
                  strobe <= 1'b1;
                  load   <= 1'b1;
                  st     <= ST_READ;
                  rcnt   <= '0;
                  armed  <= 1'b0;
               end
            end
            ST_READ: begin
               if (!cs_lo && ctl.intclk) armed <= 1'b1;
               if (cs_lo && fall) begin
                  shift <= 1'b1;
                  rcnt  <= rcnt + 1'b1;
                  if (rcnt == R_LAST) st <= ST_IDLE;
               end else if (cs_lo && rise && din_s && armed) begin
                  st   <= ST_CMD;
                  fcnt <= '0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
   import sarp_pkg::*;
#(
   parameter int W           = 16,
   parameter int CONV_CYCLES = 700,
   parameter int SHORT_EDGE  = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_n,
   input  logic         sclk,
   input  logic         din,
   input  logic [W-1:0] res_data,
   output logic         dout,
   output logic         strobe,
   output logic         strobe_oe,
   output logic         conv_start,
   output logic [6:0]   ctl_word
);
   generate
      if (W < 9) begin : g_bad_w
         $error("sar_serial_port: W must be at least 9");
      end
   endgenerate

   logic        cs_s, sclk_s, din_s, sclk_d;
   logic        sclk_rise, sclk_fall;
   logic        load, shift, int_mode;
   sarp_state_e st;
   sarp_ctl_t   ctl;

   sarp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   sarp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   sarp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
      .clk(clk), .rst_n(rst_n), .d(din), .q(din_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;

   sarp_seq #(.W(W), .CONV_CYCLES(CONV_CYCLES), .SHORT_EDGE(SHORT_EDGE)) u_seq (
      .clk(clk), .rst_n(rst_n), .cs_lo(~cs_s), .rise(sclk_rise), .fall(sclk_fall),
      .din_s(din_s), .st(st), .ctl(ctl), .conv_start(conv_start), .strobe(strobe),
      .load(load), .shift(shift));

   sarp_shift #(.W(W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .unip(ctl.unip),
      .res(res_data), .dout(dout));

   assign int_mode  = ctl.intclk;
   assign strobe_oe = int_mode | ~cs_n;
   assign ctl_word  = ctl;
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk
   import sarp_pkg::*;
#(
   parameter int CONV_CYCLES = 700
) (
   input logic        clk,
   input logic        rst_n,
   input logic        strobe,
   input logic        conv_start,
   input logic        dout,
   input logic        int_mode,
   input sarp_state_e st
);
   localparam int LW = $clog2(CONV_CYCLES + 2) + 1;

   logic [LW-1:0] lowcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         lowcnt <= '0;
      else if (conv_start && int_mode)    lowcnt <= LW'(1);
      else if (lowcnt != '0 && !strobe)   lowcnt <= lowcnt + 1'b1;
      else                                lowcnt <= '0;
   end

   assert_conv_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_strobe_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lowcnt <= LW'(CONV_CYCLES));

   assert_zero_tail_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && $past(st) == ST_READ) |=> !dout);

   assert_ext_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_mode && !conv_start && $fell(strobe)) |-> st == ST_READ);
endmodule

bind sar_serial_port sar_serial_port_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .strobe(strobe), .conv_start(conv_start),
   .dout(dout), .int_mode(int_mode), .st(st));

// File: tb/sar_serial_port_tb.sv
module sar_serial_port_tb;
   localparam int W    = 16;
   localparam int CONV = 700;
   localparam int SHE  = 11;
   localparam int H    = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
   logic [W-1:0] res_data = '0;
   logic dout, strobe, strobe_oe, conv_start;
   logic [6:0] ctl_word;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int lowcnt = 0;
   int measured = 0;
   bit running = 0;

   always #5 clk = ~clk;

   sar_serial_port #(.W(W), .CONV_CYCLES(CONV), .SHORT_EDGE(SHE)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .res_data(res_data), .dout(dout), .strobe(strobe), .strobe_oe(strobe_oe),
      .conv_start(conv_start), .ctl_word(ctl_word));

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (conv_start) begin
         running <= 1;
         lowcnt  <= 1;
      end else if (running && !strobe) begin
         lowcnt <= lowcnt + 1;
      end else if (running && strobe) begin
         running  <= 0;
         measured <= lowcnt;
      end
   end

   always @(negedge clk) begin
      if (cyc > 190000) begin
         errors = errors + 1;
         $display("FAIL watchdog: act %0d exp below 190000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: act %0h exp %0h", tag, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one SCLK period: rise, fall, then settle low
   task automatic clk_bit(input logic d);
      @(negedge clk);
      din = d;
      waitc(H);
      sclk = 1'b1;
      waitc(H);
      sclk = 1'b0;
      waitc(H);
   endtask

   task automatic send_cmd(input logic [6:0] cw);
      cs_n = 1'b0;
      waitc(H);
      clk_bit(1'b1);
      for (int i = 6; i >= 0; i--) clk_bit(cw[i]);
      chk(ctl_word == cw, "R1 ctl_word", ctl_word, cw);
   endtask

   task automatic ext_xfer(input logic [6:0] cw, input logic [W-1:0] val,
                           input bit split, input bit noise);
      int e;
      logic [W-1:0] exp;
      e   = cw[4] ? W - 1 : SHE;
      exp = cw[6] ? val : (val ^ 16'h8000);
      res_data = val;
      send_cmd(cw);
      chk(strobe_oe == 1'b1, "R5 oe with cs low", strobe_oe, 1);
      for (int f = 9; f <= e + 18; f++) begin
         if (split && (f % 8 == 1)) begin
            cs_n = 1'b1;
            waitc(6);
            chk(strobe_oe == 1'b0, "R5 oe with cs high", strobe_oe, 0);
            for (int j = 0; j < 3; j++) begin
               sclk = 1'b1; waitc(H); sclk = 1'b0; waitc(H);
            end
            cs_n = 1'b0;
            waitc(H);
         end
         clk_bit((noise && f <= e + 16) ? 1'b1 : 1'b0);
         if (f <= e + 1)
            chk(strobe == (f == e), split ? "R6 strobe split" : "R3 strobe", strobe, (f == e));
         if (f >= e + 1) begin
            int k;
            k = f - (e + 1);
            if (k < W)
               chk(dout == exp[W-1-k], noise ? "R11 R4 dout" : (cw[6] ? "R4 dout" : "R9 R4 dout"),
                   dout, exp[W-1-k]);
            else
               chk(dout == 1'b0, "R10 zero tail", dout, 0);
         end
      end
      chk(ctl_word == cw, "R11 ctl unchanged", ctl_word, cw);
      cs_n = 1'b1;
      waitc(2 * H);
   endtask

   task automatic int_xfer(input logic [6:0] cw, input logic [W-1:0] val,
                           input bit cs_off, input int stop_after);
      logic [W-1:0] exp;
      int guard;
      exp = cw[6] ? val : (val ^ 16'h8000);
      res_data = val;
      send_cmd(cw);
      chk(strobe == 1'b0, "R7 strobe low in conv", strobe, 0);
      if (cs_off) begin
         cs_n = 1'b1;
         waitc(5);
         chk(strobe_oe == 1'b1, "R5 oe internal", strobe_oe, 1);
      end
      guard = 0;
      while (!strobe && guard < 5 * CONV) begin
         waitc(1);
         guard++;
      end
      waitc(3);
      chk(measured == CONV, "R7 conv time", measured, CONV);
      chk(dout == exp[W-1], cw[6] ? "R7 msb" : "R9 R7 msb", dout, exp[W-1]);
      waitc(50);
      chk(strobe == 1'b1, "R7 strobe held", strobe, 1);
      cs_n = 1'b0;
      waitc(H);
      for (int k = 1; k <= W + 1; k++) begin
         if (k > stop_after) break;
         clk_bit(1'b0);
         if (k < W) chk(dout == exp[W-1-k], "R8 dout", dout, exp[W-1-k]);
         else       chk(dout == 1'b0, "R10 zero tail", dout, 0);
      end
      cs_n = 1'b1;
      waitc(2 * H);
   endtask

   initial begin
      waitc(5);
      chk(dout == 1'b0,      "R12 dout reset", dout, 0);
      chk(strobe == 1'b0,    "R12 strobe reset", strobe, 0);
      chk(strobe_oe == 1'b0, "R12 oe reset", strobe_oe, 0);
      chk(ctl_word == 7'd0,  "R12 ctl reset", ctl_word, 0);
      rst_n = 1'b1;
      waitc(5);
      for (int mode = 0; mode < 3; mode++) begin
         for (int ub = 0; ub < 2; ub++) begin
            for (int vi = 0; vi < 6; vi++) begin
               logic [W-1:0] v;
               logic [6:0]   cw;
               v = (vi == 0) ? 16'h0000 : (vi == 1) ? 16'hFFFF :
                   W'(16'hA5C3 + vi * 16'h1F07 + mode * 16'h0331);
               cw = {ub[0], (mode == 2) ? 1'b1 : 1'b0, (mode == 0) ? 1'b1 : 1'b0,
                     vi[0], 3'(vi + mode)};
               if (mode == 2) int_xfer(cw, v, vi[0], W + 1);
               else           ext_xfer(cw, v, vi[0], vi[1]);
            end
         end
      end
      // R11: aborted internal readout, cs high, then a new start bit
      int_xfer(7'b1100101, 16'h3C5A, 1'b0, 5);
      ext_xfer(7'b0010011, 16'h9E21, 1'b0, 1'b0);
      int_xfer(7'b0100110, 16'h7FFF, 1'b1, W + 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule